// File: doc/BRIEF.md
# Half-Rate Run-Length-Limited Line Codec

This block carries a serial bit stream over one wire while keeping the wire from sitting low for long. It has a transmit half and a receive half, and both use one shared clock and one shared slot phase. The phase alternates on every clock. A new payload bit is taken only in the cycles the phase marks as strobe cycles, so the line runs at twice the payload rate. Each payload bit takes two line cycles. The first is a spacer cycle, which is driven high only when the payload bit before it and the new payload bit are both zero. The second is the payload bit itself. This rule keeps every run of low line cycles to three or fewer.

The receive half samples its line input only in strobe cycles and holds that sample on its data output. It flags the sample as valid in the cycle that follows. Just after reset the line still carries its idle value and no payload, so the first sample is meaningless. A guard of two flops keeps the valid flag low until that transient has passed. With the line looped back, every payload bit comes out three cycles after it went in, and no bit is lost.

Top module: `rll_codec`

## Requirements
- R1: `encStrobe` is 1 in the first cycle after reset and alternates on every clock after that. `encDin` is used only in cycles where `encStrobe` is 1 and has no effect in the other cycles.
- R2: `lineOut` is never 0 for more than three consecutive cycles.
- R3: In the cycle after a strobe cycle, `lineOut` is 1 if and only if the bit taken in that strobe cycle and the bit taken at the strobe before it are both 0. Before the first bit after reset, the earlier bit counts as 1.
- R4: Two cycles after a strobe cycle, `lineOut` equals the `encDin` value taken in that strobe cycle.
- R5: At the end of each strobe cycle, `decDout` takes the value of `lineIn` and holds it for two cycles. `lineIn` has no effect in cycles where `encStrobe` is 0.
- R6: `decValid` is never 1 in a strobe cycle. Once the guard has expired, it is 1 in every cycle where `encStrobe` is 0.
- R7: While reset is asserted, `lineOut` is 1, `encStrobe` is 1 and `decValid` is 0, without waiting for a clock edge. After reset is released, `decValid` stays 0 for cycles 0, 1 and 2 and first rises in cycle 3.
- R8: With `lineIn` tied to `lineOut`, `decDout` in each cycle where `decValid` is 1 equals the `encDin` bit taken three cycles earlier. This holds for the first bit after reset, and no bit is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rstN | input | 1 | Asynchronous reset, active low |
| encDin | input | 1 | Payload bit, used in strobe cycles only |
| encStrobe | output | 1 | High in cycles where `encDin` is used and `lineIn` is sampled |
| lineOut | output | 1 | Coded line driven by the transmit half |
| lineIn | input | 1 | Coded line seen by the receive half |
| decDout | output | 1 | Recovered payload bit |
| decValid | output | 1 | One-cycle flag: `decDout` holds a recovered bit |

## Verification
The hardest case to reach from the ports is a maximal low run. It needs a 1 followed by a 0, a 1 and then a 0 again, and it must also cover the startup case, where the first clock cycle is driven low against the idle high line. The bench reaches all of these by streaming every 8-bit value back to back, which covers every neighbouring pair of bits across byte boundaries, and by adding a mid-run reset whose first byte is zero. To show that the receive half ignores the spacer cycles, the loopback is broken. The bench then forces a line pattern in which each spacer cycle carries the opposite of the payload cycle before it, so a decoder that sampled in the wrong phase would give the wrong answer.

// File: rtl/rll_codec_pkg.sv
package rll_codec_pkg;

  // Longest run of low line cycles that the coding rule allows.
  localparam int MAX_ZERO_RUN = 3;

  // Strobes from the control part to the datapath.
  typedef struct packed {
    logic dataSlot;  // payload bit is taken now and the line is sampled now
    logic guardOn;   // startup transient still in progress
  } slotCtrl_t;

endpackage

// File: rtl/rll_codec_ctrl.sv
module rll_codec_ctrl
  import rll_codec_pkg::*;
#(
  parameter int GUARD_LEN = 2
) (
  input  logic      clk,
  input  logic      rstN,
  output slotCtrl_t ctrl
);

  logic                 phaseQ;
  logic [GUARD_LEN-1:0] guardQ;

  // Slot phase: 0 marks a strobe cycle, and the value flips on every clock.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phaseQ <= 1'b0;
    else       phaseQ <= ~phaseQ;
  end

  // Guard: loaded with ones at reset, then zeros shift in.
  generate
    if (GUARD_LEN == 1) begin : g_guardSingle
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) guardQ <= '1;
        else       guardQ <= 1'b0;
      end
    end else begin : g_guardChain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) guardQ <= '1;
        else       guardQ <= {guardQ[GUARD_LEN-2:0], 1'b0};
      end
    end
  endgenerate

  assign ctrl.dataSlot = ~phaseQ;
  assign ctrl.guardOn  = |guardQ;

endmodule

// File: rtl/rll_codec_dp.sv
module rll_codec_dp
  import rll_codec_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  slotCtrl_t ctrl,
  input  logic      encDin,
  input  logic      lineIn,
  output logic      lineOut,
  output logic      decDout,
  output logic      decValid
);

  logic curBitQ;   // most recent payload bit, reset to 1 so startup stays legal
  logic lineQ;
  logic doutQ;
  logic validQ;

  // Transmit: spacer cycle first, payload cycle second.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curBitQ <= 1'b1;
      lineQ   <= 1'b1;
    end else if (ctrl.dataSlot) begin
      lineQ   <= ~curBitQ & ~encDin;
      curBitQ <= encDin;
    end else begin
      lineQ   <= curBitQ;
    end
  end

  // Receive: sample in strobe cycles only; the guard masks the flag.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doutQ  <= 1'b0;
      validQ <= 1'b0;
    end else begin
      if (ctrl.dataSlot) doutQ <= lineIn;
      validQ <= ctrl.dataSlot & ~ctrl.guardOn;
    end
  end

  assign lineOut  = lineQ;
  assign decDout  = doutQ;
  assign decValid = validQ;

endmodule

// File: rtl/rll_codec.sv
module rll_codec
  import rll_codec_pkg::*;
#(
  parameter int GUARD_LEN = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic encDin,
  output logic encStrobe,
  output logic lineOut,
  input  logic lineIn,
  output logic decDout,
  output logic decValid
);

  slotCtrl_t ctrl;

  rll_codec_ctrl #(.GUARD_LEN(GUARD_LEN)) u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .ctrl (ctrl)
  );

  rll_codec_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .encDin   (encDin),
    .lineIn   (lineIn),
    .lineOut  (lineOut),
    .decDout  (decDout),
    .decValid (decValid)
  );

  assign encStrobe = ctrl.dataSlot;

endmodule

// File: rtl/rll_codec_chk.sv
module rll_codec_chk
  import rll_codec_pkg::*;
(
  input logic clk,
  input logic rstN,
  input logic encDin,
  input logic encStrobe,
  input logic lineOut,
  input logic lineIn,
  input logic decDout,
  input logic decValid
);

  logic [2:0] zeroRun;
  logic       lastDin;
  logic [1:0] sinceRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      zeroRun  <= '0;
      lastDin  <= 1'b1;
      sinceRst <= '0;
    end else begin
      if (lineOut) zeroRun <= '0;
      else if (zeroRun != 3'd7) zeroRun <= zeroRun + 3'd1;
      if (encStrobe) lastDin <= encDin;
      if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
    end
  end

  AST_STROBE_TOGGLE: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (encStrobe != $past(encStrobe)));  // R1

  AST_ZERO_RUN: assert property (@(posedge clk) disable iff (!rstN)
    !((zeroRun == 3'(MAX_ZERO_RUN)) && !lineOut));  // R2

  AST_SPACER_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    encStrobe |=> (lineOut == (!$past(encDin) && !$past(lastDin))));  // R3

  AST_PAYLOAD_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    (!encStrobe && $past(encStrobe)) |=> (lineOut == $past(encDin, 2)));  // R4

  AST_SAMPLE_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    decValid |-> (decDout == $past(lineIn)));  // R5

  AST_VALID_PHASE: assert property (@(posedge clk) disable iff (!rstN)
    decValid |-> !encStrobe);  // R6

  AST_VALID_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    (!encStrobe && sinceRst == 2'd3) |-> decValid);  // R6

  AST_GUARD_MASK: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst != 2'd3) |-> !decValid);  // R7

endmodule

bind rll_codec rll_codec_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .encDin    (encDin),
  .encStrobe (encStrobe),
  .lineOut   (lineOut),
  .lineIn    (lineIn),
  .decDout   (decDout),
  .decValid  (decValid)
);

// File: tb/rll_codec_bench.sv
module rll_codec_bench;

  localparam int NB = 2048;   // every 8-bit value, most significant bit first
  localparam int FORCED = 40;

  logic clk = 1'b0;
  logic rstN = 1'b1;
  logic encDin = 1'b0;
  logic loopBack = 1'b1;
  logic forcedLine = 1'b0;
  logic encStrobe, lineOut, lineIn, decDout, decValid;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  logic sentBits [0:NB+15];
  logic forcedAt [0:FORCED-1];

  assign lineIn = loopBack ? lineOut : forcedLine;

  rll_codec u_rll_codec (
    .clk       (clk),
    .rstN      (rstN),
    .encDin    (encDin),
    .encStrobe (encStrobe),
    .lineOut   (lineOut),
    .lineIn    (lineIn),
    .decDout   (decDout),
    .decValid  (decValid)
  );

  always #10 clk = ~clk;

  task automatic chk(input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", what, act, exp);
    end
  endtask

  function automatic logic streamBit(input int k);
    if (k < NB) return logic'((8'(k / 8) >> (7 - k % 8)) & 8'd1);
    return 1'b0;
  endfunction

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    #2;
    chk("R7 reset lineOut", lineOut, 1'b1);
    chk("R7 reset encStrobe", encStrobe, 1'b1);
    chk("R7 reset decValid", decValid, 1'b0);
    repeat (2) @(negedge clk);
    loopBack = 1'b1;
    rstN = 1'b1;
  endtask

  // Cycle 0 is the current cycle, right after reset is released.
  task automatic runStream(input int cycles);
    logic sentPrev = 1'b1;
    logic sentLast = 1'b1;
    int zeros = 0;
    for (int c = 0; c < cycles; c++) begin
      if (c > 0) @(negedge clk);
      chk($sformatf("R1 strobe cycle %0d", c), encStrobe, logic'(c % 2 == 0));
      if (c == 0)
        chk("R7 idle line cycle 0", lineOut, 1'b1);
      else if (c % 2 == 1)
        chk($sformatf("R3 spacer cycle %0d", c), lineOut, !sentPrev && !sentLast);
      else
        chk($sformatf("R4 payload cycle %0d", c), lineOut, sentLast);
      if (lineOut) zeros = 0; else zeros++;
      chk($sformatf("R2 zero run cycle %0d", c), logic'(zeros > 3), 1'b0);
      if (c < 3)
        chk($sformatf("R7 guard cycle %0d", c), decValid, 1'b0);
      else
        chk($sformatf("R6 valid cycle %0d", c), decValid, logic'(c % 2 == 1));
      if (c >= 3 && c % 2 == 1)
        chk($sformatf("R8 data cycle %0d", c), decDout, sentBits[(c - 3) / 2]);
      if (c % 2 == 0) begin
        sentBits[c / 2] = streamBit(c / 2);
        encDin = sentBits[c / 2];
        sentPrev = sentLast;
        sentLast = sentBits[c / 2];
      end else begin
        encDin = ~sentLast;  // R1: this value must have no effect
      end
    end
  endtask

  // Loopback is broken here; odd slots carry the opposite of the slot before.
  task automatic runForced();
    for (int j = 0; j < FORCED; j++) begin
      @(negedge clk);
      if (j >= 1 && j % 2 == 1)
        chk($sformatf("R5 sample slot %0d", j), decDout, forcedAt[j - 1]);
      if (j >= 2 && j % 2 == 0)
        chk($sformatf("R5 hold slot %0d", j), decDout, forcedAt[j - 2]);
      if (j >= 1)
        chk($sformatf("R6 forced valid %0d", j), decValid, logic'(j % 2 == 1));
      if (j % 2 == 0) forcedAt[j] = logic'((((j >> 1) * 3) >> 1) & 1);
      else            forcedAt[j] = ~forcedAt[j - 1];
      forcedLine = forcedAt[j];
      loopBack = 1'b0;
    end
  endtask

  initial begin
    #1 rstN = 1'b0;
    doReset();
    runStream(2 * NB + 8);
    runForced();
    doReset();
    runStream(24);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule